// File: doc/BRIEF.md
# Vector Mixed-Sign Byte Multiply-Sum Unit

This execution unit works on three 128-bit vector operands. Each 128-bit vector is split into four 32-bit words, and each word holds four bytes. For each word, the unit multiplies every byte of the first source, read as a signed weight, by the byte in the same position of the second source, read as an unsigned sample. It adds the four products together and then adds that total to the matching word of the third source, which acts as a signed accumulator. The four result words wrap modulo 2^32.

A second mode treats both byte sources as unsigned. The unit picks the mode by decoding a 32-bit instruction word in the three-source vector format. It checks the primary opcode and the extended opcode. Any encoding it does not support is flagged as illegal, and the result is forced to zero.

The caller presents the operands and the instruction word together with `valid_in`. One clock later the registered result appears together with `valid_out`. The destination and source register numbers come out with the result, so the caller can perform the write-back.

Top module: `vmsum_mixbyte_unit`

## Requirements
- R1: In mixed mode (extended opcode 37), result word i equals accumulator word i plus the sum over j = 0..3 of signed(A byte 4i+j) × unsigned(B byte 4i+j).
- R2: Lanes are numbered big-endian. Byte k occupies vector bits [127-8k -: 8], and word i occupies bits [127-32i -: 32]. Word i is built only from bytes 4i..4i+3.
- R3: The sum wraps modulo 2^32. There is no saturation and no extra output.
- R4: The accumulator words are signed 32-bit values. A negative accumulator lowers the result.
- R5: Extended opcode 36 selects unsigned mode, which follows the R1 formula but reads the A bytes as unsigned.
- R6: The instruction fields are numbered with bit 0 as the MSB. The primary opcode is instr[31:26] and must equal 4. The destination field is instr[25:21], A is [20:16], B is [15:11], C is [10:6], and the extended opcode is [5:0].
- R7: If the primary opcode is not 4, or the extended opcode is neither 36 nor 37, `illegal_out` is 1 in the same cycle as `valid_out` and `result` is zero.
- R8: `valid_out` is 1 exactly in the cycle after a cycle with `valid_in` high, and 0 in every other cycle.
- R9: An asynchronous active-low reset clears `valid_out`, `illegal_out`, `result` and the register outputs to zero.
- R10: The four register fields of the captured instruction appear on `dst_reg`, `ra_reg`, `rb_reg` and `rc_reg` with the result. The register numbers, including aliased ones, do not change the computed value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_in | input | 1 | Operands and instruction present this cycle |
| instr | input | 32 | Instruction word |
| src_a | input | 128 | Weight bytes |
| src_b | input | 128 | Sample bytes |
| src_c | input | 128 | Four signed 32-bit accumulators |
| valid_out | output | 1 | Result valid |
| illegal_out | output | 1 | Unsupported encoding |
| result | output | 128 | Four 32-bit sums |
| dst_reg | output | 5 | Destination register number |
| ra_reg | output | 5 | Source A register number |
| rb_reg | output | 5 | Source B register number |
| rc_reg | output | 5 | Source C register number |

## Verification
The bench sweeps every A byte value against every B byte value, in both modes, and compares each result with an arithmetic model. A unit that zero-extended the weights would return large positive values where the model expects -128 × 255 = -32640 per product. A unit that sign-extended the samples would turn a 255 sample into -1.

Directed cases cover several other faults:
- Accumulators at 0x7FFFFFFF and 0x80000000 expose a design that saturates or mishandles the carry out of bit 31.
- A single nonzero byte placed at position 0 and then at position 15 exposes reversed lane numbering.
- Wrong primary or extended opcodes expose a decoder that reads the fields little-endian or lets an unsupported code through.

// File: rtl/vmsum_pkg.sv
package vmsum_pkg;
    localparam int unsigned LANES          = 4;
    localparam int unsigned BYTES_PER_LANE = 4;
    localparam int unsigned BYTE_W         = 8;
    localparam int unsigned WORD_W         = BYTES_PER_LANE * BYTE_W;
    localparam int unsigned VEC_W          = LANES * WORD_W;
    localparam int unsigned INSTR_W        = 32;
    localparam int unsigned OPC_W          = 6;
    localparam int unsigned REG_W          = 5;
    localparam int unsigned XO_W           = 6;
    localparam logic [OPC_W-1:0] PRIMARY_OP  = 6'd4;
    localparam logic [XO_W-1:0]  XO_MIXED    = 6'd37;
    localparam logic [XO_W-1:0]  XO_UNSIGNED = 6'd36;

    typedef enum logic [1:0] {
        MODE_MIXED    = 2'd0,
        MODE_UNSIGNED = 2'd1,
        MODE_ILLEGAL  = 2'd2
    } mode_e;

    typedef struct packed {
        logic [REG_W-1:0] rt;
        logic [REG_W-1:0] ra;
        logic [REG_W-1:0] rb;
        logic [REG_W-1:0] rc;
    } regs_t;

    typedef struct packed {
        logic             valid;
        logic             illegal;
        logic [VEC_W-1:0] result;
        regs_t            regs;
    } stage_t;
endpackage

// File: rtl/vmsum_decode.sv
module vmsum_decode
    import vmsum_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output mode_e              mode,
    output regs_t              regs
);
    localparam int unsigned RT_HI = INSTR_W - OPC_W - 1;
    localparam int unsigned RA_HI = RT_HI - REG_W;
    localparam int unsigned RB_HI = RA_HI - REG_W;
    localparam int unsigned RC_HI = RB_HI - REG_W;

    logic [OPC_W-1:0] opc;
    logic [XO_W-1:0]  xo;

    always_comb begin
        opc     = instr[INSTR_W-1 -: OPC_W];
        xo      = instr[XO_W-1:0];
        regs.rt = instr[RT_HI -: REG_W];
        regs.ra = instr[RA_HI -: REG_W];
        regs.rb = instr[RB_HI -: REG_W];
        regs.rc = instr[RC_HI -: REG_W];
        if (opc != PRIMARY_OP)      mode = MODE_ILLEGAL;
        else if (xo == XO_MIXED)    mode = MODE_MIXED;
        else if (xo == XO_UNSIGNED) mode = MODE_UNSIGNED;
        else                        mode = MODE_ILLEGAL;
    end
endmodule

// File: rtl/vmsum_lane.sv
module vmsum_lane #(
    parameter int unsigned NB = 4,
    parameter int unsigned BW = 8,
    parameter int unsigned WW = 32
) (
    input  logic [NB*BW-1:0] a_word,
    input  logic [NB*BW-1:0] b_word,
    input  logic [WW-1:0]    acc,
    input  logic             unsigned_mode,
    output logic [WW-1:0]    sum
);
    localparam int unsigned PW  = 2 * BW + 2;
    localparam int unsigned EXT = WW - PW;

    logic [WW-1:0] prod_ext [NB];

    for (genvar j = 0; j < NB; j++) begin : g_prod
        logic [BW-1:0]          a_byte;
        logic [BW-1:0]          b_byte;
        logic signed [BW:0]     a_op;
        logic signed [BW:0]     b_op;
        logic signed [PW-1:0]   prod;
        always_comb begin
            a_byte      = a_word[NB*BW-1-BW*j -: BW];
            b_byte      = b_word[NB*BW-1-BW*j -: BW];
            a_op        = {(unsigned_mode ? 1'b0 : a_byte[BW-1]), a_byte};
            b_op        = {1'b0, b_byte};
            prod        = PW'(a_op * b_op);
            prod_ext[j] = {{EXT{prod[PW-1]}}, prod};
        end
    end

    always_comb begin
        sum = acc;
        for (int j = 0; j < NB; j++) begin
            sum = sum + prod_ext[j];
        end
    end
endmodule

// File: rtl/vmsum_mixbyte_unit.sv
module vmsum_mixbyte_unit
    import vmsum_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               valid_in,
    input  logic [INSTR_W-1:0] instr,
    input  logic [VEC_W-1:0]   src_a,
    input  logic [VEC_W-1:0]   src_b,
    input  logic [VEC_W-1:0]   src_c,
    output logic               valid_out,
    output logic               illegal_out,
    output logic [VEC_W-1:0]   result,
    output logic [REG_W-1:0]   dst_reg,
    output logic [REG_W-1:0]   ra_reg,
    output logic [REG_W-1:0]   rb_reg,
    output logic [REG_W-1:0]   rc_reg
);
    mode_e            mode;
    regs_t            dec_regs;
    logic [VEC_W-1:0] lane_vec;
    stage_t           st_d;
    stage_t           st_q;

    vmsum_decode u_decode (
        .instr (instr),
        .mode  (mode),
        .regs  (dec_regs)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [WORD_W-1:0] lane_sum;
        vmsum_lane #(
            .NB (BYTES_PER_LANE),
            .BW (BYTE_W),
            .WW (WORD_W)
        ) u_lane (
            .a_word        (src_a[VEC_W-1-WORD_W*i -: WORD_W]),
            .b_word        (src_b[VEC_W-1-WORD_W*i -: WORD_W]),
            .acc           (src_c[VEC_W-1-WORD_W*i -: WORD_W]),
            .unsigned_mode (mode == MODE_UNSIGNED),
            .sum           (lane_sum)
        );
        assign lane_vec[VEC_W-1-WORD_W*i -: WORD_W] = lane_sum;
    end

    always_comb begin
        st_d         = st_q;
        st_d.valid   = valid_in;
        st_d.illegal = valid_in && (mode == MODE_ILLEGAL);
        if (valid_in) begin
            st_d.result = (mode == MODE_ILLEGAL) ? '0 : lane_vec;
            st_d.regs   = dec_regs;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_out   = st_q.valid;
    assign illegal_out = st_q.illegal;
    assign result      = st_q.result;
    assign dst_reg     = st_q.regs.rt;
    assign ra_reg      = st_q.regs.ra;
    assign rb_reg      = st_q.regs.rb;
    assign rc_reg      = st_q.regs.rc;
endmodule

// File: rtl/vmsum_mixbyte_checker.sv
module vmsum_mixbyte_checker (
    input logic         clk,
    input logic         rst_n,
    input logic         valid_in,
    input logic [31:0]  instr,
    input logic         valid_out,
    input logic         illegal_out,
    input logic [127:0] result,
    input logic [4:0]   dst_reg,
    input logic [4:0]   rc_reg
);
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in |=> valid_out); // R8
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> !valid_out); // R8
    AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_out |-> (valid_out && result == '0)); // R7
    AST_BAD_XO: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && instr[31:26] == 6'd4 && instr[5:0] != 6'd36 && instr[5:0] != 6'd37)
        |=> illegal_out); // R7
    AST_BAD_PRIMARY: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && instr[31:26] != 6'd4) |=> illegal_out); // R6
    AST_MIXED_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && instr[31:26] == 6'd4 && instr[5:0] == 6'd37) |=> !illegal_out); // R1
    AST_UNSIGNED_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && instr[31:26] == 6'd4 && instr[5:0] == 6'd36) |=> !illegal_out); // R5
    AST_FIELDS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in |=> (dst_reg == $past(instr[25:21]) && rc_reg == $past(instr[10:6]))); // R10
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |-> (!valid_out && !illegal_out && result == '0)); // R9
endmodule

bind vmsum_mixbyte_unit vmsum_mixbyte_checker u_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .valid_in    (valid_in),
    .instr       (instr),
    .valid_out   (valid_out),
    .illegal_out (illegal_out),
    .result      (result),
    .dst_reg     (dst_reg),
    .rc_reg      (rc_reg)
);

// File: tb/vmsum_mixbyte_unit_bench.sv
module vmsum_mixbyte_unit_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         valid_in = 1'b0;
    logic [31:0]  instr = '0;
    logic [127:0] src_a = '0;
    logic [127:0] src_b = '0;
    logic [127:0] src_c = '0;
    logic         valid_out;
    logic         illegal_out;
    logic [127:0] result;
    logic [4:0]   dst_reg, ra_reg, rb_reg, rc_reg;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    vmsum_mixbyte_unit u_vmsum_mixbyte_unit (
        .clk (clk), .rst_n (rst_n), .valid_in (valid_in), .instr (instr),
        .src_a (src_a), .src_b (src_b), .src_c (src_c),
        .valid_out (valid_out), .illegal_out (illegal_out), .result (result),
        .dst_reg (dst_reg), .ra_reg (ra_reg), .rb_reg (rb_reg), .rc_reg (rc_reg)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: actual %0d cycles, expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    function automatic logic [31:0] mk(input logic [5:0] po, input logic [4:0] rt, ra, rb, rc,
                                       input logic [5:0] xo);
        return {po, rt, ra, rb, rc, xo};
    endfunction

    function automatic logic [127:0] model(input bit uns, input logic [127:0] a, b, c);
        logic [127:0] r;
        for (int w = 0; w < 4; w++) begin
            int acc;
            acc = int'(c[127-32*w -: 32]);
            for (int j = 0; j < 4; j++) begin
                logic [7:0] ab, bb;
                ab = a[127-8*(4*w+j) -: 8];
                bb = b[127-8*(4*w+j) -: 8];
                if (uns) acc = acc + int'(ab) * int'(bb);
                else     acc = acc + int'($signed(ab)) * int'(bb);
            end
            r[127-32*w -: 32] = acc;
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [127:0] act, exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive at a falling edge, check at the next falling edge (one register stage).
    task automatic run_op(input logic [31:0] ins, input logic [127:0] a, b, c, input string tag);
        logic [127:0] exp;
        bit ill;
        ill = (ins[31:26] != 6'd4) || (ins[5:0] != 6'd36 && ins[5:0] != 6'd37);
        exp = ill ? 128'd0 : model(ins[5:0] == 6'd36, a, b, c);
        valid_in = 1'b1; instr = ins; src_a = a; src_b = b; src_c = c;
        @(negedge clk);
        valid_in = 1'b0;
        check(valid_out == 1'b1, {tag, " R8 valid_out"}, 128'(valid_out), 128'd1);
        check(illegal_out == ill, {tag, " R7 illegal"}, 128'(illegal_out), 128'(ill));
        check(result == exp, {tag, " result"}, result, exp);
        check({dst_reg, ra_reg, rb_reg, rc_reg} == ins[25:6], {tag, " R10 fields"},
              128'({dst_reg, ra_reg, rb_reg, rc_reg}), 128'(ins[25:6]));
    endtask

    initial begin
        logic [31:0] mix_i, uns_i;
        mix_i = mk(6'd4, 5'd0, 5'd0, 5'd0, 5'd0, 6'd37);
        uns_i = mk(6'd4, 5'd0, 5'd0, 5'd0, 5'd0, 6'd36);
        repeat (3) @(negedge clk);
        check(valid_out == 0 && illegal_out == 0 && result == 0, "R9 reset state",
              result, 128'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(mix_i == 32'h10000025, "R6 encoding", 128'(mix_i), 128'h10000025);

        // R1 / R4 / R2 directed
        run_op(mix_i, {16{8'h80}}, {16{8'hFF}}, '0, "R1 min x max");
        check(result[127:96] == 32'hFFFE_0200, "R1 -130560 word", 128'(result[127:96]), 128'hFFFE0200);
        run_op(mix_i, '0, '0, {4{32'hFFFF_FFFB}}, "R4 negative acc");
        check(result[31:0] == 32'hFFFF_FFFB, "R4 acc -5", 128'(result[31:0]), 128'hFFFFFFFB);
        run_op(mix_i, {8'h01, 120'd0}, {8'h07, 120'd0}, '0, "R2 byte0");
        check(result == {32'd7, 96'd0}, "R2 byte0 to word0", result, {32'd7, 96'd0});
        run_op(mix_i, 128'h01, 128'h07, '0, "R2 byte15");
        check(result == 128'd7, "R2 byte15 to word3", result, 128'd7);
        // R3 wrap
        run_op(mix_i, {16{8'h01}}, {16{8'h01}}, {4{32'h7FFF_FFFF}}, "R3 wrap up");
        check(result[95:64] == 32'h8000_0003, "R3 wrap to negative", 128'(result[95:64]), 128'h80000003);
        run_op(mix_i, {16{8'hFF}}, {16{8'h01}}, {4{32'h8000_0000}}, "R3 wrap down");
        check(result[63:32] == 32'h7FFF_FFFC, "R3 wrap to positive", 128'(result[63:32]), 128'h7FFFFFFC);
        // R5 unsigned corner
        run_op(uns_i, {16{8'hFF}}, {16{8'hFF}}, '0, "R5 unsigned max");
        check(result[31:0] == 32'h0003_F804, "R5 4x65025", 128'(result[31:0]), 128'h3F804);
        // R6 / R7 illegal encodings
        run_op(mk(6'd5, 5'd1, 5'd2, 5'd3, 5'd4, 6'd37), {16{8'h11}}, {16{8'h22}}, '1, "R6 bad primary");
        run_op(32'h25000004, {16{8'h11}}, {16{8'h22}}, '1, "R6 reversed fields");
        run_op(mk(6'd4, 5'd9, 5'd2, 5'd3, 5'd4, 6'd38), {16{8'h11}}, {16{8'h22}}, '1, "R7 bad xo");
        // R8 idle cycle
        @(negedge clk);
        check(valid_out == 0 && illegal_out == 0, "R8 no valid without input", 128'(valid_out), 128'd0);
        // R10 aliasing and field passthrough
        run_op(mk(6'd4, 5'd7, 5'd7, 5'd7, 5'd7, 6'd37), {16{8'h9C}}, {16{8'h33}}, {4{32'd1000}}, "R10 aliased");
        run_op(mk(6'd4, 5'd31, 5'd1, 5'd16, 5'd5, 6'd37), {16{8'h9C}}, {16{8'h33}}, {4{32'd1000}}, "R10 distinct");

        // R1 / R5 sweep of every A byte against every B byte
        for (int ai = 0; ai < 256; ai++) begin
            for (int g = 0; g < 16; g++) begin
                logic [127:0] b, c;
                for (int k = 0; k < 16; k++) b[127-8*k -: 8] = 8'(g * 16 + k);
                c = {4{32'(ai * 977 + g * 65537)}};
                run_op(mix_i, {16{8'(ai)}}, b, c, "R1 sweep");
                run_op(uns_i, {16{8'(ai)}}, b, c, "R5 sweep");
            end
        end
        // random vectors, both modes
        for (int n = 0; n < 1000; n++) begin
            logic [127:0] a, b, c;
            a = {$urandom, $urandom, $urandom, $urandom};
            b = {$urandom, $urandom, $urandom, $urandom};
            c = {$urandom, $urandom, $urandom, $urandom};
            run_op(mk(6'd4, 5'($urandom), 5'($urandom), 5'($urandom), 5'($urandom),
                      (n % 2 == 0) ? 6'd37 : 6'd36), a, b, c, "R1 R5 random");
        end

        // R9 asynchronous reset mid-run
        valid_in = 1'b1; instr = mix_i; src_a = {16{8'h01}}; src_b = {16{8'h01}}; src_c = '0;
        @(negedge clk);
        valid_in = 1'b0;
        #1 rst_n = 1'b0;
        #0.5;
        check(valid_out == 0 && result == 0, "R9 async clear", result, 128'd0);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule